// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block steers one disk data transfer across a series of host memory chunks that a descriptor-driven DMA engine supplies. A start pulse arms the sequencer. It loads the byte budget (sector count times 512 for a hard disk, the packet byte count for an optical drive) and clears a running byte index. Each chunk then arrives as an address and length pair. The sequencer turns it into a single block request whose device byte offset comes from the starting block address and the running index. It advances its counters and acknowledges the chunk once the storage side reports the request done.

When a chunk arrives after the budget is used up, the sequencer finishes the transfer. It pulses a completion strobe, raises the drive interrupt and disarms. A zero-length chunk closes only the current DMA pass. A chunk that arrives while the sequencer is unarmed is handed back as paused. An optical transfer whose block address is all ones is a non-block packet copy: a single request of min(budget, chunk length) bytes that completes the transfer when it returns. A storage error aborts the transfer. At most one request is outstanding at any time.

Top module: `disk_xfer_seq`

## Requirements
- R1: After reset `armed_o`, `irq_o`, `req_valid_o`, `chunk_ack_o`, `done_o` and `fail_o` are all low.
- R2: An accepted start arms the block (`armed_o` high) and clears `irq_o`. It loads the budget as `sectors_i`×512 when `optical_i` is 0, or as `pkt_bytes_i` when `optical_i` is 1, and resets the running index to 0.
- R3: The request offset is (`lba_i` << 9) + index for a hard disk and (`lba_i` << 11) + index for an optical drive. The result is a 64-bit sum.
- R4: A non-empty chunk accepted while armed, with budget left, issues one request with `req_len_o` equal to the chunk length and `req_addr_o` equal to the chunk address. It then reduces the budget and advances the index by that length. The chunk is acknowledged with code 0 (consumed) one cycle after `req_done_i`.
- R5: A chunk offered while unarmed is acknowledged with code 1 (paused) one cycle after it is offered, and no request is issued.
- R6: A chunk offered while armed with a budget of zero or less is acknowledged with code 3 (finished), together with a one-cycle `done_o` pulse, `irq_o` high and `armed_o` low.
- R7: A zero-length chunk while armed with budget left is acknowledged with code 2 (pass end). The block stays armed and the counters are unchanged.
- R8: In optical mode with `lba_i` all ones, a chunk issues one request of kind 3 with offset 0 and length min(budget, chunk length). Its completion acknowledges the chunk with code 3, pulses `done_o` and disarms.
- R9: `req_err_i` on an outstanding request acknowledges the chunk with code 4 (abort), pulses `fail_o`, raises `irq_o` and disarms.
- R10: The request kind is the command for a hard disk (0 read, 1 write, 2 trim) and is always 0 (read) for an optical drive. A hard-disk start with command 3 is refused: `fail_o` pulses, `irq_o` rises and the block stays unarmed.
- R11: While a request is outstanding, no further request and no chunk acknowledge is produced until `req_done_i` or `req_err_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new transfer |
| optical_i | input | 1 | 1 selects optical addressing, 0 hard disk |
| cmd_i | input | 2 | Command: 0 read, 1 write, 2 trim, 3 illegal |
| sectors_i | input | 16 | Sector count (hard disk) |
| lba_i | input | 32 | Starting block address |
| pkt_bytes_i | input | 32 | Packet byte count (optical) |
| chunk_valid_i | input | 1 | A host chunk is offered; held until acknowledged |
| chunk_addr_i | input | 32 | Host address of the chunk |
| chunk_len_i | input | 32 | Byte length of the chunk |
| req_done_i | input | 1 | Outstanding request completed |
| req_err_i | input | 1 | Outstanding request failed |
| req_valid_o | output | 1 | One-cycle request strobe |
| req_kind_o | output | 2 | 0 read, 1 write, 2 trim, 3 packet copy |
| req_offset_o | output | 64 | Device byte offset of the request |
| req_addr_o | output | 32 | Host address of the request |
| req_len_o | output | 32 | Byte length of the request |
| chunk_ack_o | output | 1 | One-cycle chunk acknowledge |
| ack_code_o | output | 3 | 0 consumed, 1 paused, 2 pass end, 3 finished, 4 abort |
| armed_o | output | 1 | Transfer armed |
| done_o | output | 1 | One-cycle transfer completion pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| irq_o | output | 1 | Drive interrupt level |

## Verification
A request strobe, a paused, pass-end or finished acknowledge, and the failure pulse of a refused start all appear in the cycle after the edge that samples the chunk or start. A consumed or abort acknowledge appears in the cycle after the edge that samples `req_done_i` or `req_err_i`. The bench changes inputs on the falling edge and reads outputs exactly one falling edge later, so every check lands in the cycle the result is due. While a request is outstanding, the bench holds the chunk offered for several idle cycles and checks that nothing new appears.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_WR   = 2'd1,
    CMD_TRIM = 2'd2,
    CMD_BAD  = 2'd3
  } cmd_e;

  localparam logic [1:0] KIND_PKT = 2'd3;

  typedef enum logic [2:0] {
    ACK_CONSUMED = 3'd0,
    ACK_PAUSED   = 3'd1,
    ACK_PASS_END = 3'd2,
    ACK_FINISHED = 3'd3,
    ACK_ABORT    = 3'd4
  } ack_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2,
    ST_PKT   = 2'd3
  } st_e;
endpackage

// File: rtl/dxs_counters.sv
module dxs_counters #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] step_len_i,
  output logic [LEN_W-1:0] remaining_o,
  output logic [LEN_W-1:0] index_o
);
  logic [LEN_W-1:0] rem_q, rem_n;
  logic [LEN_W-1:0] idx_q, idx_n;

  always_comb begin
    rem_n = rem_q;
    idx_n = idx_q;
    if (load_i) begin
      rem_n = load_val_i;
      idx_n = '0;
    end else if (step_i) begin
      rem_n = rem_q - step_len_i;
      idx_n = idx_q + step_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_n;
      idx_q <= idx_n;
    end
  end

  assign remaining_o = rem_q;
  assign index_o     = idx_q;
endmodule

// File: rtl/dxs_offset.sv
module dxs_offset #(
  parameter int LBA_W = 32,
  parameter int LEN_W = 32,
  parameter int OFF_W = 64,
  parameter int SHIFT = 9
) (
  input  logic [LBA_W-1:0] lba_i,
  input  logic [LEN_W-1:0] index_i,
  output logic [OFF_W-1:0] offset_o
);
  assign offset_o = (OFF_W'(lba_i) << SHIFT) + OFF_W'(index_i);
endmodule

// File: rtl/dxs_ctrl.sv
module dxs_ctrl
  import dxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       start_bad_i,
  input  logic       chunk_valid_i,
  input  logic       chunk_zero_i,
  input  logic       pkt_mode_i,
  input  logic       rem_empty_i,
  input  logic       req_done_i,
  input  logic       req_err_i,
  output logic       load_o,
  output logic       step_o,
  output logic       issue_o,
  output logic       issue_pkt_o,
  output logic       chunk_ack_o,
  output logic [2:0] ack_code_o,
  output logic       done_o,
  output logic       fail_o,
  output logic       irq_o,
  output logic       armed_o
);
  st_e  st_q, st_n;
  ack_e code_q, code_n;
  logic ack_q, ack_n;
  logic done_q, done_n;
  logic fail_q, fail_n;
  logic irq_q, irq_n;
  logic idle;

  assign idle = (st_q == ST_OFF) || (st_q == ST_ARMED);

  always_comb begin
    st_n        = st_q;
    code_n      = code_q;
    ack_n       = 1'b0;
    done_n      = 1'b0;
    fail_n      = 1'b0;
    irq_n       = irq_q;
    load_o      = 1'b0;
    step_o      = 1'b0;
    issue_o     = 1'b0;
    issue_pkt_o = 1'b0;
    if (idle && start_i) begin
      if (start_bad_i) begin
        fail_n = 1'b1;
        irq_n  = 1'b1;
        st_n   = ST_OFF;
      end else begin
        load_o = 1'b1;
        irq_n  = 1'b0;
        st_n   = ST_ARMED;
      end
    end else if (idle && chunk_valid_i && !ack_q) begin
      if (st_q == ST_OFF) begin
        ack_n  = 1'b1;
        code_n = ACK_PAUSED;
      end else if (rem_empty_i) begin
        ack_n  = 1'b1;
        code_n = ACK_FINISHED;
        done_n = 1'b1;
        irq_n  = 1'b1;
        st_n   = ST_OFF;
      end else if (chunk_zero_i) begin
        ack_n  = 1'b1;
        code_n = ACK_PASS_END;
      end else if (pkt_mode_i) begin
        issue_o     = 1'b1;
        issue_pkt_o = 1'b1;
        st_n        = ST_PKT;
      end else begin
        issue_o = 1'b1;
        step_o  = 1'b1;
        st_n    = ST_BUSY;
      end
    end else if (!idle) begin
      if (req_err_i) begin
        ack_n  = 1'b1;
        code_n = ACK_ABORT;
        fail_n = 1'b1;
        irq_n  = 1'b1;
        st_n   = ST_OFF;
      end else if (req_done_i) begin
        ack_n = 1'b1;
        if (st_q == ST_PKT) begin
          code_n = ACK_FINISHED;
          done_n = 1'b1;
          irq_n  = 1'b1;
          st_n   = ST_OFF;
        end else begin
          code_n = ACK_CONSUMED;
          st_n   = ST_ARMED;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      code_q <= ACK_CONSUMED;
      ack_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      code_q <= code_n;
      ack_q  <= ack_n;
      done_q <= done_n;
      fail_q <= fail_n;
      irq_q  <= irq_n;
    end
  end

  assign chunk_ack_o = ack_q;
  assign ack_code_o  = code_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign irq_o       = irq_q;
  assign armed_o     = (st_q != ST_OFF);
endmodule

// File: rtl/disk_xfer_seq.sv
module disk_xfer_seq
  import dxs_pkg::*;
#(
  parameter int SECT_W    = 16,
  parameter int LBA_W     = 32,
  parameter int LEN_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 64,
  parameter int DISK_SHIFT = 9,
  parameter int OPT_SHIFT  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              optical_i,
  input  logic [1:0]        cmd_i,
  input  logic [SECT_W-1:0] sectors_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [LEN_W-1:0]  pkt_bytes_i,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  input  logic              req_done_i,
  input  logic              req_err_i,
  output logic              req_valid_o,
  output logic [1:0]        req_kind_o,
  output logic [OFF_W-1:0]  req_offset_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              chunk_ack_o,
  output logic [2:0]        ack_code_o,
  output logic              armed_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              irq_o
);
  localparam int NMODE = 2;

  logic             cfg_opt_q;
  logic [1:0]       cfg_cmd_q;
  logic [LBA_W-1:0] cfg_lba_q;
  logic             load, step, issue, issue_pkt;
  logic [LEN_W-1:0] load_val, remaining, index;
  logic [LEN_W-1:0] pkt_len;
  logic             rem_empty, start_bad, pkt_mode;
  logic [OFF_W-1:0] offs [NMODE];
  logic [OFF_W-1:0] offset_sel;
  logic [1:0]       kind_n;

  assign start_bad = !optical_i && (cmd_i == CMD_BAD);
  assign load_val  = optical_i ? pkt_bytes_i
                               : (LEN_W'(sectors_i) << DISK_SHIFT);
  assign rem_empty = remaining[LEN_W-1] || (remaining == '0);
  assign pkt_mode  = cfg_opt_q && (&cfg_lba_q);
  assign pkt_len   = (remaining < chunk_len_i) ? remaining : chunk_len_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_opt_q <= 1'b0;
      cfg_cmd_q <= CMD_RD;
      cfg_lba_q <= '0;
    end else if (load) begin
      cfg_opt_q <= optical_i;
      cfg_cmd_q <= cmd_i;
      cfg_lba_q <= lba_i;
    end
  end

  dxs_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (step),
    .step_len_i (chunk_len_i),
    .remaining_o(remaining),
    .index_o    (index)
  );

  for (genvar g = 0; g < NMODE; g++) begin : g_off
    dxs_offset #(
      .LBA_W(LBA_W), .LEN_W(LEN_W), .OFF_W(OFF_W),
      .SHIFT((g == 0) ? DISK_SHIFT : OPT_SHIFT)
    ) u_off (
      .lba_i   (cfg_lba_q),
      .index_i (index),
      .offset_o(offs[g])
    );
  end

  assign offset_sel = cfg_opt_q ? offs[1] : offs[0];
  assign kind_n     = issue_pkt ? KIND_PKT : (cfg_opt_q ? CMD_RD : cfg_cmd_q);

  dxs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_bad_i  (start_bad),
    .chunk_valid_i(chunk_valid_i),
    .chunk_zero_i (chunk_len_i == '0),
    .pkt_mode_i   (pkt_mode),
    .rem_empty_i  (rem_empty),
    .req_done_i   (req_done_i),
    .req_err_i    (req_err_i),
    .load_o       (load),
    .step_o       (step),
    .issue_o      (issue),
    .issue_pkt_o  (issue_pkt),
    .chunk_ack_o  (chunk_ack_o),
    .ack_code_o   (ack_code_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .irq_o        (irq_o),
    .armed_o      (armed_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid_o <= 1'b0;
    end else begin
      req_valid_o <= issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_kind_o   <= CMD_RD;
      req_offset_o <= '0;
      req_addr_o   <= '0;
      req_len_o    <= '0;
    end else if (issue) begin
      req_kind_o   <= kind_n;
      req_offset_o <= issue_pkt ? '0 : offset_sel;
      req_addr_o   <= chunk_addr_i;
      req_len_o    <= issue_pkt ? pkt_len : chunk_len_i;
    end
  end
endmodule

// File: rtl/disk_xfer_seq_chk.sv
module disk_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       req_done_i,
  input logic       req_err_i,
  input logic       req_valid_o,
  input logic [1:0] req_kind_o,
  input logic [63:0] req_offset_o,
  input logic       chunk_ack_o,
  input logic [2:0] ack_code_o,
  input logic       armed_o,
  input logic       done_o,
  input logic       fail_o,
  input logic       irq_o
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (req_valid_o) outstanding <= 1'b1;
    else if (req_done_i || req_err_i) outstanding <= 1'b0;
  end

  // R11: no second request, no acknowledge while one is in flight
  a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> (!req_valid_o && !chunk_ack_o));

  // R5: an unarmed block issues no request on the following cycle
  a_r5_no_req_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !start_i) |=> !req_valid_o);

  // R6: completion leaves the block disarmed with the interrupt up
  a_r6_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!armed_o && irq_o && chunk_ack_o));

  // R9: a failure leaves the block disarmed with the interrupt up
  a_r9_fail_irq: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (!armed_o && irq_o));

  // R7: a pass-end acknowledge keeps the transfer armed
  a_r7_pass_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_ack_o && ack_code_o == 3'd2) |-> armed_o);

  // R8: packet-copy requests carry offset zero
  a_r8_pkt_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_kind_o == 2'd3) |-> (req_offset_o == 64'd0));
endmodule

bind disk_xfer_seq disk_xfer_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .req_done_i  (req_done_i),
  .req_err_i   (req_err_i),
  .req_valid_o (req_valid_o),
  .req_kind_o  (req_kind_o),
  .req_offset_o(req_offset_o),
  .chunk_ack_o (chunk_ack_o),
  .ack_code_o  (ack_code_o),
  .armed_o     (armed_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .irq_o       (irq_o)
);

// File: tb/tb_disk_xfer_seq.sv
`timescale 1ns/1ps
module tb_disk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, optical;
  logic [1:0]  cmd;
  logic [15:0] sectors;
  logic [31:0] lba, pkt_bytes;
  logic        cv;
  logic [31:0] caddr, clen;
  logic        rdone, rerr;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [63:0] req_offset;
  logic [31:0] req_addr, req_len;
  logic        ack;
  logic [2:0]  ack_code;
  logic        armed, done, fail, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  disk_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .optical_i(optical),
    .cmd_i(cmd), .sectors_i(sectors), .lba_i(lba), .pkt_bytes_i(pkt_bytes),
    .chunk_valid_i(cv), .chunk_addr_i(caddr), .chunk_len_i(clen),
    .req_done_i(rdone), .req_err_i(rerr),
    .req_valid_o(req_valid), .req_kind_o(req_kind), .req_offset_o(req_offset),
    .req_addr_o(req_addr), .req_len_o(req_len),
    .chunk_ack_o(ack), .ack_code_o(ack_code), .armed_o(armed),
    .done_o(done), .fail_o(fail), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic opt, input logic [1:0] c, input logic [15:0] s,
                          input logic [31:0] l, input logic [31:0] p);
    @(negedge clk);
    optical = opt; cmd = c; sectors = s; lba = l; pkt_bytes = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Offers a chunk; returns at the negedge one cycle later (valid still high)
  task automatic offer(input logic [31:0] a, input logic [31:0] n);
    @(negedge clk);
    cv = 1'b1; caddr = a; clen = n;
    @(negedge clk);
  endtask

  task automatic finish_req(input logic err);
    @(negedge clk);
    rdone = !err; rerr = err;
    @(negedge clk);
    rdone = 1'b0; rerr = 1'b0;
  endtask

  task automatic expect_req(input string tag, input logic [1:0] k, input logic [63:0] off,
                            input logic [31:0] a, input logic [31:0] n);
    chk({tag, " req_valid"}, req_valid, 1);
    chk({tag, " kind"}, req_kind, k);
    chk({tag, " offset"}, req_offset, off);
    chk({tag, " addr"}, req_addr, a);
    chk({tag, " len"}, req_len, n);
    chk({tag, " no ack"}, ack, 0);
  endtask

  task automatic expect_ack(input string tag, input logic [2:0] code);
    chk({tag, " ack"}, ack, 1);
    chk({tag, " code"}, ack_code, code);
    chk({tag, " no req"}, req_valid, 0);
    cv = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 armed", armed, 0);
    chk("R1 irq", irq, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 ack", ack, 0);
    chk("R1 done/fail", {done, fail}, 0);
  endtask

  task automatic t_pause();
    offer(32'h40, 32'd512);
    expect_ack("R5 paused", 3'd1);
    chk("R5 armed", armed, 0);
  endtask

  task automatic t_disk_write();
    do_start(1'b0, 2'd1, 16'd2, 32'd5, 32'd0);
    chk("R2 armed", armed, 1);
    chk("R2 irq cleared", irq, 0);
    offer(32'h100, 32'd512);
    expect_req("R3 R10 disk write 1", 2'd1, 64'd2560, 32'h100, 32'd512);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 quiet while outstanding", {req_valid, ack}, 0);
    end
    finish_req(1'b0);
    expect_ack("R4 consumed", 3'd0);
    offer(32'h200, 32'd512);
    expect_req("R4 disk write 2", 2'd1, 64'd3072, 32'h200, 32'd512);
    finish_req(1'b0);
    expect_ack("R4 consumed 2", 3'd0);
    offer(32'h300, 32'd64);
    chk("R6 done", done, 1);
    chk("R6 irq", irq, 1);
    chk("R6 armed", armed, 0);
    expect_ack("R6 finished", 3'd3);
  endtask

  task automatic t_optical();
    do_start(1'b1, 2'd1, 16'd0, 32'd3, 32'd4096);
    offer(32'h1000, 32'd0);
    chk("R7 armed", armed, 1);
    expect_ack("R7 pass end", 3'd2);
    offer(32'h2000, 32'd2048);
    expect_req("R3 R7 R10 optical 1", 2'd0, 64'd6144, 32'h2000, 32'd2048);
    finish_req(1'b0);
    expect_ack("R4 optical consumed", 3'd0);
    offer(32'h3000, 32'd2048);
    expect_req("R3 optical 2", 2'd0, 64'd8192, 32'h3000, 32'd2048);
    finish_req(1'b0);
    expect_ack("R4 optical consumed 2", 3'd0);
    offer(32'h4000, 32'd16);
    chk("R6 optical done", done, 1);
    expect_ack("R6 optical finished", 3'd3);
  endtask

  task automatic t_packet(input logic [31:0] n, input logic [31:0] exp_len);
    do_start(1'b1, 2'd0, 16'd0, 32'hFFFF_FFFF, 32'd100);
    offer(32'h5000, n);
    expect_req("R8 packet", 2'd3, 64'd0, 32'h5000, exp_len);
    finish_req(1'b0);
    chk("R8 done", done, 1);
    chk("R8 armed", armed, 0);
    expect_ack("R8 finished", 3'd3);
  endtask

  task automatic t_trim();
    do_start(1'b0, 2'd2, 16'd1, 32'd0, 32'd0);
    offer(32'h6000, 32'd512);
    expect_req("R10 trim", 2'd2, 64'd0, 32'h6000, 32'd512);
    finish_req(1'b0);
    expect_ack("R10 trim consumed", 3'd0);
    offer(32'h6200, 32'd512);
    expect_ack("R6 trim finished", 3'd3);
  endtask

  task automatic t_error();
    do_start(1'b0, 2'd0, 16'd4, 32'd10, 32'd0);
    offer(32'h7000, 32'd512);
    expect_req("R9 read req", 2'd0, 64'd5120, 32'h7000, 32'd512);
    finish_req(1'b1);
    chk("R9 fail", fail, 1);
    chk("R9 irq", irq, 1);
    chk("R9 armed", armed, 0);
    expect_ack("R9 abort", 3'd4);
    offer(32'h7200, 32'd512);
    expect_ack("R5 paused after abort", 3'd1);
  endtask

  task automatic t_illegal();
    do_start(1'b0, 2'd3, 16'd1, 32'd0, 32'd0);
    chk("R10 illegal fail", fail, 1);
    chk("R10 illegal irq", irq, 1);
    chk("R10 illegal armed", armed, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; optical = 1'b0; cmd = 2'd0; sectors = '0;
    lba = '0; pkt_bytes = '0; cv = 1'b0; caddr = '0; clen = '0;
    rdone = 1'b0; rerr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pause();
    t_disk_write();
    t_optical();
    t_packet(32'd512, 32'd100);
    t_packet(32'd40, 32'd40);
    t_trim();
    t_error();
    t_illegal();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule